// File: doc/BRIEF.md
# Two-Tier Swapping Line Controller

This block sits between one requester and two equal-sized line memories: a fast near tier and a slow far tier. Together they form a single flat address space twice the size of either tier. The low address bits pick a slot. Every slot owns one near location and one far location. The top address bit picks which of the slot's two member lines is meant. A one-bit occupancy flag for each slot records which member currently lives in the near location.

When the requested member is already near, the block serves it from near memory, and the far tier is not touched. When the member is far, the block reads both locations and writes each line into the other tier. It then flips the slot's flag and completes the request with the line the requester asked for. Every line always has exactly one home, so no capacity is lost to copies. Write requests carry a byte strobe. A hit write updates the near location in place. A miss write first swaps the pair and then merges the new bytes into the line that has just arrived in the near location.

Requests use a valid/ready handshake and are served one at a time. Each response is a single-cycle pulse. Two saturating counters record near hits and near misses, so the hit rate can be computed from them. A synchronous clear input resets both counters.

Top module: `tier_swap_ctrl`

## Requirements
- R1: After reset, every slot's flag is 0 (member 0 is near), every line of both tiers reads as zero, req_ready is 1, rsp_valid is 0, and both counters are 0.
- R2: A read whose selector bit req_addr[SLOT_BITS] equals the slot's flag is a hit. Its response comes MEM_LAT cycles after the accepting edge, with rsp_hit=1 and the line last written to that address.
- R3: A hit write changes only the strobed bytes of the near copy. Its response comes 1 cycle after acceptance, with rsp_hit=1 and rsp_rdata all zero.
- R4: A read that misses swaps the pair and flips the flag. Its response comes MEM_LAT+1 cycles after acceptance, with rsp_hit=0 and the requested line. Afterwards that address hits and its partner misses.
- R5: A write that misses swaps the pair, then merges the strobed bytes into the requested line. Its response comes MEM_LAT+1 cycles after acceptance, with rsp_hit=0 and zero data. The partner line's contents are preserved.
- R6: req_ready is 0 from the accepting edge until the edge that raises rsp_valid. A request held during that time is neither accepted nor counted.
- R7: Each accepted hit adds 1 to hit_count, and each accepted miss adds 1 to miss_count. The new value is visible in the cycle after the accepting edge.
- R8: Each counter stops at 2^CNT_W-1 and stays there.
- R9: stat_clr zeroes both counters at the next edge. It takes priority over a request accepted on that edge, which is then not counted.
- R10: Bit i of req_wstrb enables write byte i, which is req_wdata[8i+7:8i]. Disabled bytes keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | SLOT_BITS+1 | Flat line address: bit SLOT_BITS is the member selector, the lower bits are the slot |
| req_wdata | input | 8*LINE_BYTES | Write line |
| req_wstrb | input | LINE_BYTES | Byte enables for the write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | 1 if the request was served near without a swap |
| rsp_rdata | output | 8*LINE_BYTES | Read line (zero for writes) |
| stat_clr | input | 1 | Synchronous clear of both counters |
| hit_count | output | CNT_W | Saturating near-hit count |
| miss_count | output | CNT_W | Saturating near-miss count |

## Verification
A behavioural model holds one line per flat address and one flag per slot, and the bench compares it with the outputs on every cycle. Repeated reads of one address separate the first-touch miss from the hits that follow. Reads that alternate between the two members of a slot miss on every request, which shows that each swap really moves both lines and that the partner's data survives the swap. Full and partial-strobe writes, both hit and miss, check byte merging against the line's previous contents. Back-to-back requests held during a swap, a counter clear that coincides with an acceptance, and long runs with narrow counters check the handshake, clear priority and saturation.

// File: rtl/tsc_pkg.sv
// Shared types for the two-tier swapping controller.
// Assumes: a single outstanding request at a time.
package tsc_pkg;

    // Controller phases: idle, waiting on tier reads, committing writes.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_COMMIT = 2'd2
    } tsc_state_e;

endpackage

// File: rtl/tsc_line_mem.sv
// Behavioural line memory with a fixed read latency and byte-enabled writes.
// Read data is sampled at issue and appears RD_LAT cycles later with rd_vld.
// Assumes RD_LAT >= 1. Contents clear to zero on reset.
module tsc_line_mem #(
    parameter int IDX_W  = 5,
    parameter int LINE_W = 512,
    parameter int RD_LAT = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic                  rd_vld,
    output logic [LINE_W-1:0]     rd_data,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [LINE_W-1:0]     wr_data,
    input  logic [LINE_W/8-1:0]   wr_be
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int BYTES = LINE_W / 8;

    logic [LINE_W-1:0] store_q [DEPTH];
    logic              vld_q   [RD_LAT];
    logic [LINE_W-1:0] dat_q   [RD_LAT];

    // Storage: cleared on reset, byte-masked update on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[b]) store_q[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    // Read pipeline: data captured at issue, shifted for RD_LAT cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < RD_LAT; s++) begin
                vld_q[s] <= 1'b0;
                dat_q[s] <= '0;
            end
        end else begin
            vld_q[0] <= rd_en;
            dat_q[0] <= rd_en ? store_q[rd_idx] : '0;
            for (int s = 1; s < RD_LAT; s++) begin
                vld_q[s] <= vld_q[s-1];
                dat_q[s] <= dat_q[s-1];
            end
        end
    end

    assign rd_vld  = vld_q[RD_LAT-1];
    assign rd_data = dat_q[RD_LAT-1];

endmodule

// File: rtl/tsc_occupancy.sv
// Per-slot occupancy flags: 0 means member 0 is in the near tier.
// One combinational lookup port and one flip port.
module tsc_occupancy #(
    parameter int SLOT_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_BITS-1:0] look_slot,
    output logic                 look_flag,
    input  logic                 flip_en,
    input  logic [SLOT_BITS-1:0] flip_slot
);
    localparam int SLOTS = 1 << SLOT_BITS;

    logic [SLOTS-1:0] flag_q;

    // Flags: all zero on reset, one slot toggles per completed swap.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= '0;
        else if (flip_en) flag_q[flip_slot] <= ~flag_q[flip_slot];
    end

    assign look_flag = flag_q[look_slot];

endmodule

// File: rtl/tsc_stats.sv
// Saturating hit and miss counters with a synchronous clear that wins.
module tsc_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit_inc,
    input  logic             miss_inc,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             inc_v [2];
    logic [CNT_W-1:0] cnt_q [2];

    assign inc_v[0] = hit_inc;
    assign inc_v[1] = miss_inc;

    for (genvar k = 0; k < 2; k++) begin : g_cnt
        // Counter k: clear first, else saturating increment.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                     cnt_q[k] <= '0;
            else if (inc_v[k] && cnt_q[k] != CNT_MAX) cnt_q[k] <= cnt_q[k] + 1'b1;
        end

        // R7
        cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (cnt_q[k] >= $past(cnt_q[k])));
        // R8
        cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[k] == CNT_MAX && !clr) |=> (cnt_q[k] == CNT_MAX));
        // R9
        cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (cnt_q[k] == '0));
    end

    assign hit_cnt  = cnt_q[0];
    assign miss_cnt = cnt_q[1];

endmodule

// File: rtl/tier_swap_ctrl.sv
// Two-tier swapping controller. The flat address {sel, slot} names one of a
// pair of lines sharing a near slot and a far slot. Hits are served from near;
// misses exchange the pair and then complete. One request at a time.
// Assumes both tiers have the same fixed read latency MEM_LAT.
module tier_swap_ctrl
    import tsc_pkg::*;
#(
    parameter int SLOT_BITS  = 5,
    parameter int LINE_BYTES = 64,
    parameter int MEM_LAT    = 3,
    parameter int CNT_W      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [SLOT_BITS:0]        req_addr,
    input  logic [LINE_BYTES*8-1:0]   req_wdata,
    input  logic [LINE_BYTES-1:0]     req_wstrb,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [LINE_BYTES*8-1:0]   rsp_rdata,
    input  logic                      stat_clr,
    output logic [CNT_W-1:0]          hit_count,
    output logic [CNT_W-1:0]          miss_count
);
    localparam int LINE_W = LINE_BYTES * 8;

    tsc_state_e            state_q;
    logic [SLOT_BITS-1:0]  slot_in, slot_q;
    logic                  sel_in, flag_in, hit_in, accept;
    logic                  wr_q, hit_q;
    logic [LINE_W-1:0]     wdata_q, near_line_q, far_line_q, merged;
    logic [LINE_BYTES-1:0] wstrb_q, mstrb;
    logic                  rsp_valid_q, rsp_hit_q;
    logic [LINE_W-1:0]     rsp_rdata_q;

    logic                  near_re, far_re, near_rv, far_rv, rd_done;
    logic [LINE_W-1:0]     near_rd, far_rd;
    logic                  near_we, far_we;
    logic [LINE_W-1:0]     near_wd, far_wd;
    logic [LINE_BYTES-1:0] near_be, far_be;

    // Request decode and handshake.
    assign slot_in   = req_addr[SLOT_BITS-1:0];
    assign sel_in    = req_addr[SLOT_BITS];
    assign hit_in    = (sel_in == flag_in);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Tier reads issue on the accepting edge; a hit write needs none.
    assign near_re = accept && !(hit_in && req_write);
    assign far_re  = accept && !hit_in;
    assign rd_done = hit_q ? near_rv : (near_rv && far_rv);

    // Byte merge of write data over the line arriving from far.
    assign mstrb = wr_q ? wstrb_q : '0;
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_merge
        assign merged[b*8 +: 8] = mstrb[b] ? wdata_q[b*8 +: 8] : far_line_q[b*8 +: 8];
    end

    // Commit-phase write controls for both tiers.
    always_comb begin
        near_we = 1'b0;
        near_wd = '0;
        near_be = '0;
        far_we  = 1'b0;
        far_wd  = '0;
        far_be  = '0;
        if (state_q == ST_COMMIT) begin
            near_we = 1'b1;
            if (hit_q) begin
                near_wd = wdata_q;
                near_be = wstrb_q;
            end else begin
                near_wd = merged;
                near_be = '1;
                far_we  = 1'b1;
                far_wd  = near_line_q;
                far_be  = '1;
            end
        end
    end

    // Sequencer: capture request, wait on reads, commit, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wr_q        <= 1'b0;
            hit_q       <= 1'b0;
            slot_q      <= '0;
            wdata_q     <= '0;
            wstrb_q     <= '0;
            near_line_q <= '0;
            far_line_q  <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        wr_q    <= req_write;
                        hit_q   <= hit_in;
                        slot_q  <= slot_in;
                        wdata_q <= req_wdata;
                        wstrb_q <= req_wstrb;
                        state_q <= (hit_in && req_write) ? ST_COMMIT : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rd_done) begin
                        if (hit_q) begin
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= 1'b1;
                            rsp_rdata_q <= near_rd;
                            state_q     <= ST_IDLE;
                        end else begin
                            near_line_q <= near_rd;
                            far_line_q  <= far_rd;
                            state_q     <= ST_COMMIT;
                        end
                    end
                end
                ST_COMMIT: begin
                    rsp_valid_q <= 1'b1;
                    rsp_hit_q   <= hit_q;
                    rsp_rdata_q <= (hit_q || wr_q) ? '0 : far_line_q;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_rdata = rsp_rdata_q;

    tsc_occupancy #(.SLOT_BITS(SLOT_BITS)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_slot (slot_in),
        .look_flag (flag_in),
        .flip_en   (far_we),
        .flip_slot (slot_q)
    );

    tsc_line_mem #(.IDX_W(SLOT_BITS), .LINE_W(LINE_W), .RD_LAT(MEM_LAT)) u_near (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (near_re),
        .rd_idx  (slot_in),
        .rd_vld  (near_rv),
        .rd_data (near_rd),
        .wr_en   (near_we),
        .wr_idx  (slot_q),
        .wr_data (near_wd),
        .wr_be   (near_be)
    );

    tsc_line_mem #(.IDX_W(SLOT_BITS), .LINE_W(LINE_W), .RD_LAT(MEM_LAT)) u_far (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (far_re),
        .rd_idx  (slot_in),
        .rd_vld  (far_rv),
        .rd_data (far_rd),
        .wr_en   (far_we),
        .wr_idx  (slot_q),
        .wr_data (far_wd),
        .wr_be   (far_be)
    );

    tsc_stats #(.CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stat_clr),
        .hit_inc  (accept && hit_in),
        .miss_inc (accept && !hit_in),
        .hit_cnt  (hit_count),
        .miss_cnt (miss_count)
    );

    // R6
    stall_nocount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !stat_clr) |=>
            (hit_count == $past(hit_count) && miss_count == $past(miss_count)));
    // R6
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
    // R4
    swap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        far_we |-> (near_we && near_be == '1));
    // R2
    hit_far_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !far_rv);

endmodule

// File: tb/tb_tier_swap_ctrl.sv
module tb_tier_swap_ctrl;
    localparam int SB  = 3;
    localparam int LB  = 64;
    localparam int LW  = LB * 8;
    localparam int LAT = 3;
    localparam int CW  = 5;
    localparam int NADDR = 2 << SB;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [SB:0]   req_addr = '0;
    logic [LW-1:0] req_wdata = '0;
    logic [LB-1:0] req_wstrb = '0;
    logic          rsp_valid, rsp_hit;
    logic [LW-1:0] rsp_rdata;
    logic          stat_clr = 1'b0;
    logic [CW-1:0] hit_count, miss_count;

    int total = 0;
    int bad   = 0;
    bit done_flag = 0;

    tier_swap_ctrl #(.SLOT_BITS(SB), .LINE_BYTES(LB), .MEM_LAT(LAT), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata), .stat_clr(stat_clr), .hit_count(hit_count),
        .miss_count(miss_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string got, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [LW-1:0] pat(input int s);
        logic [LW-1:0] r;
        for (int k = 0; k < LW / 32; k++)
            r[k*32 +: 32] = (s * 32'h0100_0193) ^ (k * 32'h9E37_79B9) ^ 32'hA5A5_0000;
        return r;
    endfunction

    // Behavioural reference: one line per flat address, one flag per slot.
    logic [LW-1:0] m_line [NADDR];
    bit            m_part [NADDR];
    bit            m_flag [1 << SB];
    bit            m_busy;
    longint        m_done, ecount = 0;
    int            m_hit, m_miss;
    bit            m_exp_hit, m_exp_wr, m_exp_part;
    logic [LW-1:0] m_exp_data;

    task automatic model_reset();
        for (int a = 0; a < NADDR; a++) begin m_line[a] = '0; m_part[a] = 0; end
        for (int s = 0; s < (1 << SB); s++) m_flag[s] = 0;
        m_busy = 0; m_hit = 0; m_miss = 0;
    endtask

    // Per-cycle comparison, sampled 2 ns after each rising edge.
    always @(posedge clk) begin
        bit ready_before, exp_rsp, hit, cleared;
        int slot, addr, lat;
        string tag;
        ecount++;
        #2;
        if (!rst_n) begin
            model_reset();
            chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", $sformatf("%0b", rsp_valid), "0");
            chk(hit_count == '0 && miss_count == '0, "R1 counters in reset",
                $sformatf("%0d/%0d", hit_count, miss_count), "0/0");
        end else begin
            ready_before = !m_busy;
            exp_rsp = 0;
            cleared = 0;
            if (m_busy && ecount == m_done) begin exp_rsp = 1; m_busy = 0; end
            if (req_valid && ready_before) begin
                addr = int'(req_addr);
                slot = int'(req_addr[SB-1:0]);
                hit  = (req_addr[SB] == m_flag[slot]);
                if (!stat_clr) begin
                    if (hit) begin if (m_hit < int'(CMAX)) m_hit++; end
                    else     begin if (m_miss < int'(CMAX)) m_miss++; end
                end
                lat = hit ? (req_write ? 1 : LAT) : LAT + 1;
                m_done = ecount + lat;
                m_busy = 1;
                if (!hit) m_flag[slot] = !m_flag[slot];
                m_exp_hit = hit;
                m_exp_wr  = req_write;
                m_exp_part = m_part[addr];
                if (req_write) begin
                    for (int b = 0; b < LB; b++)
                        if (req_wstrb[b]) m_line[addr][b*8 +: 8] = req_wdata[b*8 +: 8];
                    m_part[addr] = (req_wstrb != '1);
                    m_exp_data = '0;
                end else begin
                    m_exp_data = m_line[addr];
                end
            end
            if (stat_clr) begin m_hit = 0; m_miss = 0; cleared = 1; end

            chk(req_ready == !m_busy, "R6 req_ready", $sformatf("%0b", req_ready),
                $sformatf("%0b", !m_busy));
            chk(rsp_valid == exp_rsp, "R6 rsp_valid timing", $sformatf("%0b", rsp_valid),
                $sformatf("%0b", exp_rsp));
            if (exp_rsp) begin
                if (m_exp_hit) tag = m_exp_wr ? "R3 hit write" : "R2 hit read";
                else           tag = m_exp_wr ? "R5 miss write" : "R4 miss read";
                if (!m_exp_wr && m_exp_part) tag = {tag, " R10 strobe merge"};
                chk(rsp_hit == m_exp_hit, {tag, " rsp_hit"}, $sformatf("%0b", rsp_hit),
                    $sformatf("%0b", m_exp_hit));
                chk(rsp_rdata == m_exp_data, {tag, " rsp_rdata"},
                    $sformatf("%h", rsp_rdata[63:0]), $sformatf("%h", m_exp_data[63:0]));
            end
            if (cleared) tag = "R9 clear";
            else if (m_hit == int'(CMAX) || m_miss == int'(CMAX)) tag = "R8 saturation";
            else tag = "R7 counts";
            chk(int'(hit_count) == m_hit, {tag, " hit_count"}, $sformatf("%0d", hit_count),
                $sformatf("%0d", m_hit));
            chk(int'(miss_count) == m_miss, {tag, " miss_count"}, $sformatf("%0d", miss_count),
                $sformatf("%0d", m_miss));
        end
    end

    // Drive one request at a negedge and hold it until accepted.
    task automatic send(input bit wr, input int a, input logic [LW-1:0] d, input logic [LB-1:0] st);
        bit ok;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a[SB:0];
        req_wdata = d;
        req_wstrb = st;
        do begin
            ok = req_ready;
            @(negedge clk);
        end while (!ok);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        logic [LB-1:0] half;
        for (int b = 0; b < LB; b++) half[b] = b[0];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: fresh reads return zero; member 0 hits, member 1 misses.
        send(0, 0, '0, '0);
        send(0, 8, '0, '0);
        idle(6);
        // R2/R4: alternating members of slot 0.
        send(0, 8, '0, '0);
        send(0, 0, '0, '0);
        // R3: full hit write then hit read.
        send(1, 3, pat(1), '1);
        send(0, 3, '0, '0);
        // R5/R10: partial miss write into the partner, then read both.
        send(1, 11, pat(2), half);
        send(0, 11, '0, '0);
        send(0, 3, '0, '0);
        // R3/R10: partial hit write over existing data.
        send(1, 3, pat(3), ~half);
        send(0, 3, '0, '0);
        idle(2);
        // R9: clear alone, then clear on an accepting edge.
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
        stat_clr = 1'b1;
        send(0, 5, '0, '0);
        stat_clr = 1'b0;
        // R7/R8: drive hit counter to saturation.
        for (int i = 0; i < 36; i++) send(0, 5, '0, '0);
        // R8: alternating misses saturate the miss counter.
        for (int i = 0; i < 36; i++) send(i[0], (i % 2) ? 6 : 14, pat(10 + i), '1);
        idle(8);
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
        idle(3);
        done_flag = 1;
        summary();
    end

    initial begin
        #2000000;
        if (!done_flag) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

endmodule